// File: doc/BRIEF.md
# Update-Based Snooping Coherence State Controller

This block tracks the coherence state of a small line table for four snooping caches that use an update-based (write-broadcast) protocol. Each cache has a direct-mapped slot array holding a tag and a state per set. A request is one processor id, one operation code and one line address. On acceptance, the block looks up every cache at the addressed set. It finds which other caches hold the line, picks a data supplier, and commits the new state of the requester and of every other holder in the same clock edge.

A write to a line that other caches share does not invalidate them. It pushes the new value out as a bus update. The writer becomes the shared dirty owner and the other copies become clean. Each request produces one registered response one cycle later. The response reports the requester's resulting state, a hit flag, whether a cache-to-cache transfer or a bus update took place, which cache supplied the data, and whether a dirty line was displaced from the requester's slot. Per-cache counters accumulate transfers, loads served from shared copies and loads served from private copies.

Top module: `dragon_coh_ctrl`

## Requirements
- R1: After reset every slot is Invalid, every counter reads zero, no response is valid, and req_ready is 1 from the first clock after reset release.
- R2: Operation code 2 (and code 3) changes no state and no counter. The response reports the requester's current state with all event flags 0. State codes are Invalid 0, Exclusive 1, Modified 2, Shared-Clean 3, Shared-Modified 4. Operation codes are load 0 and store 1.
- R3: A cache holds a line only when its slot tag matches and its state is not Invalid. A load miss with no other holder fills the line in Exclusive, and a load hit leaves the state unchanged.
- R4: A load miss with other holders fills the line in Shared-Clean. The lowest-numbered holder supplies the data: rsp_src names it and its transfer counter increments. Any holder in Modified becomes Shared-Modified, and any holder in Exclusive becomes Shared-Clean.
- R5: On such a load, the requester's shared-access counter increments if the supplier was Shared-Clean or Shared-Modified. Its private-access counter increments if the supplier was Modified or Exclusive.
- R6: A store miss with other holders leaves the requester in Shared-Modified, flags a bus update, adds one transfer to the requester's counter, and sets every other holder to Shared-Clean.
- R7: A store miss with no other holder leaves the requester in Modified, with no transfer and no update.
- R8: A store to Exclusive gives Modified with no bus action. Loads and stores to Modified leave it Modified.
- R9: A store to Shared-Clean with other holders gives Shared-Modified, flags a bus update, adds one transfer to the requester, and drops any other Shared-Modified holder to Shared-Clean. With no other holder it gives Modified.
- R10: A store to Shared-Modified stays Shared-Modified with no update if other holders exist, and otherwise becomes Modified.
- R11: A miss whose slot holds another tag replaces that tag. rsp_evict_wb pulses for one response when the displaced state was Modified or Shared-Modified.
- R12: Every state and counter change of a request is visible in the cycle after acceptance, and rsp_valid is 1 exactly in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_cpu | input | 2 | Requesting cache id |
| req_op | input | 2 | Operation code |
| req_addr | input | 12 | Line address (low 3 bits select the set) |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_state | output | 3 | Requester's resulting line state |
| rsp_hit | output | 1 | Requester held the line before the request |
| rsp_xfer | output | 1 | A cache-to-cache transfer was counted |
| rsp_update | output | 1 | A bus update was broadcast |
| rsp_src_valid | output | 1 | A peer supplied the line |
| rsp_src | output | 2 | Id of the supplying peer |
| rsp_evict_wb | output | 1 | Dirty line displaced from the requester's slot |
| xfer_cnt | output | 64 | Per-cache transfer counters, cache 0 in the low 16 bits |
| shr_cnt | output | 64 | Per-cache shared-access counters |
| prv_cnt | output | 64 | Per-cache private-access counters |

## Verification
A directed sequence walks one line through every state pair. It separates a fill from a lone holder from a fill from a shared group, and a store on a clean shared copy from one on a dirty shared copy. Probe loads on each peer expose the peer states that a store rewrote. A same-set, different-tag store isolates the displacement pulse from the plain miss path. A long random phase then confines traffic to two sets and three tags across all four caches. This stresses supplier priority, store misses racing with shared copies, and conflict evictions. A reference model kept in the bench predicts every response and all twelve counters.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_EXC = 3'd1,
    LS_MOD = 3'd2,
    LS_SCL = 3'd3,
    LS_SMD = 3'd4
  } line_st_t;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;

  function automatic logic st_owned(line_st_t s);
    return (s == LS_EXC) || (s == LS_MOD) || (s == LS_SMD);
  endfunction

  function automatic logic st_dirty(line_st_t s);
    return (s == LS_MOD) || (s == LS_SMD);
  endfunction

  function automatic logic st_shared(line_st_t s);
    return (s == LS_SCL) || (s == LS_SMD);
  endfunction

  // Requester next state; eff is LS_INV on a miss.
  function automatic line_st_t own_next(line_st_t eff, logic store, logic others);
    line_st_t r;
    r = eff;
    if (!store) begin
      if (eff == LS_INV) r = others ? LS_SCL : LS_EXC;
    end else begin
      case (eff)
        LS_INV: r = others ? LS_SMD : LS_MOD;
        LS_EXC: r = LS_MOD;
        LS_MOD: r = LS_MOD;
        LS_SCL: r = others ? LS_SMD : LS_MOD;
        LS_SMD: r = others ? LS_SMD : LS_MOD;
        default: r = eff;
      endcase
    end
    return r;
  endfunction

  // A write that broadcasts data to the other holders.
  function automatic logic bus_update(line_st_t eff, logic store, logic others);
    return store && others && ((eff == LS_INV) || (eff == LS_SCL));
  endfunction

  // Next state of a peer that holds the line.
  function automatic line_st_t peer_next(line_st_t cur, line_st_t eff, logic store);
    line_st_t r;
    r = cur;
    if (!store && eff == LS_INV) begin
      if (cur == LS_MOD) r = LS_SMD;
      else if (cur == LS_EXC) r = LS_SCL;
    end else if (store && eff == LS_INV) begin
      r = LS_SCL;
    end else if (store && eff == LS_SCL && cur == LS_SMD) begin
      r = LS_SCL;
    end
    return r;
  endfunction

endpackage

// File: rtl/dragon_line_bank.sv
module dragon_line_bank
  import dragon_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             held_o,
  output line_st_t         st_o,
  input  logic             wr_en_i,
  input  logic             wr_tag_i,
  input  line_st_t         wr_st_i
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [SETS];
  line_st_t         st_q  [SETS];

  assign st_o   = st_q[idx_i];
  assign held_o = (tag_q[idx_i] == tag_i) && (st_q[idx_i] != LS_INV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        st_q[s]  <= LS_INV;
      end
    end else if (wr_en_i) begin
      st_q[idx_i] <= wr_st_i;
      if (wr_tag_i) tag_q[idx_i] <= tag_i;
    end
  end
endmodule

// File: rtl/dragon_peer_scan.sv
module dragon_peer_scan #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic [N-1:0]    held_i,
  input  logic [ID_W-1:0] req_id_i,
  output logic [N-1:0]    peers_o,
  output logic            any_o,
  output logic [ID_W-1:0] sup_o
);
  always_comb begin
    peers_o = held_i;
    peers_o[req_id_i] = 1'b0;
    sup_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (peers_o[i]) sup_o = ID_W'(i);
    end
  end
  assign any_o = |peers_o;
endmodule

// File: rtl/dragon_stat_cnt.sv
module dragon_stat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> cnt_o == W'($past(cnt_o) + W'(1)));
  a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/dragon_coh_ctrl.sv
module dragon_coh_ctrl
  import dragon_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 16,
  localparam int ID_W  = $clog2(N),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ID_W-1:0]    req_cpu,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [2:0]         rsp_state,
  output logic               rsp_hit,
  output logic               rsp_xfer,
  output logic               rsp_update,
  output logic               rsp_src_valid,
  output logic [ID_W-1:0]    rsp_src,
  output logic               rsp_evict_wb,
  output logic [N*CNT_W-1:0] xfer_cnt,
  output logic [N*CNT_W-1:0] shr_cnt,
  output logic [N*CNT_W-1:0] prv_cnt
);
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = req_addr[IDX_W-1:0];
  assign tag = req_addr[ADDR_W-1:IDX_W];

  logic [N-1:0] held, peers, wr_en, owned;
  line_st_t     cur_st [N];
  line_st_t     nxt_st [N];
  logic         any_peer;
  logic [ID_W-1:0] sup_id;

  // Named events for assertions and readability.
  logic     fire, is_mem, is_store, own_hit, ld_share, upd_ev, evict_ev;
  line_st_t own_eff, own_new, sup_st;
  logic [N-1:0] xfer_inc, shr_inc, prv_inc;

  assign fire     = req_valid && req_ready;
  assign is_mem   = (req_op == OP_LOAD) || (req_op == OP_STORE);
  assign is_store = (req_op == OP_STORE);
  assign own_hit  = held[req_cpu];
  assign own_eff  = own_hit ? cur_st[req_cpu] : LS_INV;
  assign own_new  = is_mem ? own_next(own_eff, is_store, any_peer) : own_eff;
  assign sup_st   = cur_st[sup_id];
  assign ld_share = is_mem && !is_store && !own_hit && any_peer;
  assign upd_ev   = is_mem && bus_update(own_eff, is_store, any_peer);
  assign evict_ev = is_mem && !own_hit && st_dirty(cur_st[req_cpu]);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cache
      dragon_line_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .idx_i(idx), .tag_i(tag),
        .held_o(held[g]), .st_o(cur_st[g]),
        .wr_en_i(wr_en[g]), .wr_tag_i(req_cpu == ID_W'(g)), .wr_st_i(nxt_st[g])
      );
      assign owned[g] = held[g] && st_owned(cur_st[g]);

      dragon_stat_cnt #(.W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .inc_i(xfer_inc[g]),
        .cnt_o(xfer_cnt[g*CNT_W +: CNT_W]));
      dragon_stat_cnt #(.W(CNT_W)) u_shr (
        .clk(clk), .rst_n(rst_n), .inc_i(shr_inc[g]),
        .cnt_o(shr_cnt[g*CNT_W +: CNT_W]));
      dragon_stat_cnt #(.W(CNT_W)) u_prv (
        .clk(clk), .rst_n(rst_n), .inc_i(prv_inc[g]),
        .cnt_o(prv_cnt[g*CNT_W +: CNT_W]));
    end
  endgenerate

  dragon_peer_scan #(.N(N), .ID_W(ID_W)) u_scan (
    .held_i(held), .req_id_i(req_cpu),
    .peers_o(peers), .any_o(any_peer), .sup_o(sup_id)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      nxt_st[i]   = cur_st[i];
      wr_en[i]    = 1'b0;
      xfer_inc[i] = 1'b0;
      shr_inc[i]  = 1'b0;
      prv_inc[i]  = 1'b0;
      if (fire && is_mem) begin
        if (req_cpu == ID_W'(i)) begin
          nxt_st[i]   = own_new;
          wr_en[i]    = 1'b1;
          xfer_inc[i] = upd_ev;
          shr_inc[i]  = ld_share && st_shared(sup_st);
          prv_inc[i]  = ld_share && !st_shared(sup_st);
        end else if (peers[i]) begin
          nxt_st[i]   = peer_next(cur_st[i], own_eff, is_store);
          wr_en[i]    = 1'b1;
          xfer_inc[i] = ld_share && (sup_id == ID_W'(i));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready     <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_state     <= 3'd0;
      rsp_hit       <= 1'b0;
      rsp_xfer      <= 1'b0;
      rsp_update    <= 1'b0;
      rsp_src_valid <= 1'b0;
      rsp_src       <= '0;
      rsp_evict_wb  <= 1'b0;
    end else begin
      req_ready     <= 1'b1;
      rsp_valid     <= fire;
      rsp_state     <= fire ? 3'(own_new) : 3'd0;
      rsp_hit       <= fire && own_hit;
      rsp_xfer      <= fire && (ld_share || upd_ev);
      rsp_update    <= fire && upd_ev;
      rsp_src_valid <= fire && ld_share;
      rsp_src       <= (fire && ld_share) ? sup_id : '0;
      rsp_evict_wb  <= fire && evict_ev;
    end
  end

  a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(owned));
  a_r12_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
  a_r11_evict_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evict_wb |-> rsp_valid && !rsp_hit);
  a_r4_src_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_src_valid |-> rsp_xfer && !rsp_update && rsp_state == 3'(LS_SCL));
  a_r6_update_owner: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_update |-> rsp_state == 3'(LS_SMD));
endmodule

// File: tb/dragon_coh_ctrl_test.sv
module dragon_coh_ctrl_test;
  localparam int N = 4, AW = 12, IW = 3, CW = 16, SETS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_cpu = '0, req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_xfer, rsp_update, rsp_src_valid, rsp_evict_wb;
  logic [2:0] rsp_state;
  logic [1:0] rsp_src;
  logic [N*CW-1:0] xfer_cnt, shr_cnt, prv_cnt;

  always #4 clk = ~clk;

  dragon_coh_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cpu(req_cpu), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_state(rsp_state), .rsp_hit(rsp_hit),
    .rsp_xfer(rsp_xfer), .rsp_update(rsp_update), .rsp_src_valid(rsp_src_valid),
    .rsp_src(rsp_src), .rsp_evict_wb(rsp_evict_wb),
    .xfer_cnt(xfer_cnt), .shr_cnt(shr_cnt), .prv_cnt(prv_cnt)
  );

  typedef struct packed {
    logic [2:0] st; logic hit, xf, up, sv; logic [1:0] src; logic ev;
    logic [N*CW-1:0] cx, cs, cp;
    logic [3:0] rq;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  int m_tag [N][SETS];
  int m_st  [N][SETS];
  int c_x[N], c_s[N], c_p[N];

  // State codes: 0 I, 1 E, 2 M, 3 SC, 4 SM
  task automatic drive(input int cpu, input int op, input int addr);
    int ix, tg, eff, sup, nst, ps;
    logic hit, ld_m, upd;
    logic [N-1:0] hold;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_cpu = 2'(cpu); req_op = 2'(op); req_addr = AW'(addr);
    ix = addr % SETS; tg = addr / SETS;
    hold = '0; sup = -1;
    for (int i = 0; i < N; i++)
      if (i != cpu && m_tag[i][ix] == tg && m_st[i][ix] != 0) begin
        hold[i] = 1'b1;
        if (sup < 0) sup = i;
      end
    hit = (m_tag[cpu][ix] == tg) && (m_st[cpu][ix] != 0);
    eff = hit ? m_st[cpu][ix] : 0;
    e = '0;
    e.hit = hit; e.st = 3'(eff);
    e.rq = (op > 1) ? 4'd2 : 4'd3;
    if (op <= 1) begin
      ld_m = (op == 0) && !hit && (hold != 0);
      upd  = (op == 1) && (hold != 0) && (eff == 0 || eff == 3);
      e.ev = !hit && (m_st[cpu][ix] == 2 || m_st[cpu][ix] == 4);
      if (op == 0) begin
        nst = hit ? eff : ((hold != 0) ? 3 : 1);
        if (ld_m) e.rq = 4'd4;
        if (hit && eff == 2) e.rq = 4'd8;
      end else begin
        if (eff == 1 || eff == 2) begin nst = 2; e.rq = 4'd8; end
        else if (hold == 0) begin nst = 2; e.rq = (eff == 0) ? 4'd7 : (eff == 3 ? 4'd9 : 4'd10); end
        else begin nst = 4; e.rq = (eff == 0) ? 4'd6 : (eff == 3 ? 4'd9 : 4'd10); end
      end
      if (e.ev) e.rq = 4'd11;
      if (ld_m) begin
        ps = m_st[sup][ix];
        c_x[sup]++;
        if (ps == 3 || ps == 4) c_s[cpu]++; else c_p[cpu]++;
        e.sv = 1'b1; e.src = 2'(sup);
      end
      if (upd) c_x[cpu]++;
      e.xf = ld_m || upd; e.up = upd;
      for (int i = 0; i < N; i++)
        if (hold[i]) begin
          if (op == 0 && !hit) begin
            if (m_st[i][ix] == 2) m_st[i][ix] = 4;
            else if (m_st[i][ix] == 1) m_st[i][ix] = 3;
          end else if (op == 1 && !hit) m_st[i][ix] = 3;
          else if (op == 1 && eff == 3 && m_st[i][ix] == 4) m_st[i][ix] = 3;
        end
      m_st[cpu][ix] = nst; m_tag[cpu][ix] = tg;
      e.st = 3'(nst);
    end
    for (int i = 0; i < N; i++) begin
      e.cx[i*CW +: CW] = CW'(c_x[i]);
      e.cs[i*CW +: CW] = CW'(c_s[i]);
      e.cp[i*CW +: CW] = CW'(c_p[i]);
    end
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 1'b0;
  endtask

  // Monitor: compares each response one cycle after acceptance (R12).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        exp_t e;
        n_chk++;
        if (q.size() == 0) begin
          n_bad++; $display("FAIL R12 unexpected response got=1 exp=0");
        end else begin
          e = q.pop_front();
          if ({rsp_state, rsp_hit, rsp_xfer, rsp_update, rsp_src_valid, rsp_src, rsp_evict_wb}
              !== {e.st, e.hit, e.xf, e.up, e.sv, e.src, e.ev}
              || xfer_cnt !== e.cx || shr_cnt !== e.cs || prv_cnt !== e.cp) begin
            n_bad++;
            $display("FAIL R%0d rsp got st=%0d hit=%b xf=%b up=%b sv=%b src=%0d ev=%b cx=%h cs=%h cp=%h exp st=%0d hit=%b xf=%b up=%b sv=%b src=%0d ev=%b cx=%h cs=%h cp=%h",
              e.rq, rsp_state, rsp_hit, rsp_xfer, rsp_update, rsp_src_valid, rsp_src,
              rsp_evict_wb, xfer_cnt, shr_cnt, prv_cnt, e.st, e.hit, e.xf, e.up, e.sv,
              e.src, e.ev, e.cx, e.cs, e.cp);
          end
        end
      end else if (rst_n && q.size() > 1) begin
        n_chk++; n_bad++;
        $display("FAIL R12 missing response got=0 exp=1");
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      c_x[i] = 0; c_s[i] = 0; c_p[i] = 0;
      for (int s = 0; s < SETS; s++) begin m_tag[i][s] = 0; m_st[i][s] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    n_chk++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || xfer_cnt !== '0 || shr_cnt !== '0 || prv_cnt !== '0) begin
      n_bad++;
      $display("FAIL R1 reset got rdy=%b v=%b cnt=%h/%h/%h exp rdy=1 v=0 cnt=0",
               req_ready, rsp_valid, xfer_cnt, shr_cnt, prv_cnt);
    end
    // R1: load from cold table must miss
    drive(2, 0, 'h0F3); idle();
    // R3 fill Exclusive, R4/R5 private supply
    drive(0, 0, 'h008);
    drive(1, 0, 'h008);
    drive(0, 0, 'h008);
    // R6 store miss with holders, R9 store on shared clean
    drive(2, 1, 'h008);
    drive(1, 1, 'h008);
    drive(2, 0, 'h008);
    drive(0, 0, 'h008);
    // R5 shared supply from lowest holder
    drive(3, 0, 'h008);
    // R10 store on shared modified with holders
    drive(1, 1, 'h008);
    // R7 store miss alone, R11 dirty displacement
    drive(3, 1, 'h010);
    drive(3, 1, 'h050);
    drive(3, 0, 'h050);
    // R2 no-op leaves state
    drive(0, 2, 'h008);
    drive(0, 3, 'h050);
    // R8 exclusive then modified
    drive(1, 0, 'h0A1);
    drive(1, 1, 'h0A1);
    drive(1, 0, 'h0A1);
    drive(1, 1, 'h0A1);
    // R10 sole shared-modified store becomes Modified
    drive(2, 0, 'h0C2);
    drive(3, 1, 'h0C2);
    drive(2, 1, 'h04A);
    drive(3, 1, 'h0C2);
    idle(); idle();
    // Random mix on two sets and three tags
    for (int k = 0; k < 600; k++) begin
      int a;
      a = int'($urandom_range(0, 2)) * SETS + int'($urandom_range(0, 1));
      drive(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)), a);
      if (k % 37 == 0) idle();
    end
    idle(); idle(); idle();
    n_chk++;
    if (q.size() != 0) begin
      n_bad++; $display("FAIL R12 pending responses got=%0d exp=0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule